// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register side of a general-purpose I/O port of 128 pins, arranged as four banks of 32. Each bank holds a direction word, an output latch and two alternate-function words. A core reaches them over a single-cycle 32-bit word register bus. Pin `n` belongs to bank `n / 32`, at bit `n % 32` of that bank's words.

Outputs are never written directly. Software ORs bits into a latch through a set register and removes them through a clear register. A pin drives the value of its latch only while its direction bit marks it as an output. A level register returns the driven value for outputs and the sampled input for inputs. The block presents the driven levels on a 128-bit vector together with a per-pin one-cycle strobe that marks real changes. It also flags reads of the level registers and accesses to holes in the map.

Edge detection, interrupts, pad circuitry and the alternate-function pin multiplexing are handled by other blocks.

Top module: `gpio_port_regs`

## Requirements
- R1: A synchronous active-high reset clears every direction, latch and alternate-function word, and drives `pin_out`, `pin_chg`, `bus_rdata`, `lvl_read_pulse` and `map_err` to zero.
- R2: A write to a bank's set register ORs `bus_wdata` into that bank's output latch. Latch bit `i` of bank `b` controls pin `32*b+i`.
- R3: A write to a bank's clear register clears every latch bit where `bus_wdata` holds a 1 and leaves the other bits unchanged.
- R4: The set and clear registers are write-only, and a read of either returns zero.
- R5: A write to a bank's direction register stores the word, where a 1 marks an output, and a read returns it.
- R6: A read of a bank's level register returns `(latch & dir) | (pin_in & ~dir)` for that bank, taking `pin_in` in the cycle of the read.
- R7: `pin_out` equals latch AND direction for every pin. It takes its new value on the same clock edge that captures the write.
- R8: `pin_chg` is high for one cycle, right after a write, exactly on the pins whose `pin_out` value changed on that edge. It is zero in every other cycle.
- R9: The lower and upper alternate-function words of banks 0 to 3 sit at 0x054/0x058, 0x05C/0x060, 0x064/0x068 and 0x06C/0x070. They are plain read/write storage.
- R10: The level, direction, set and clear registers sit at 0x000/0x00C/0x018/0x024 plus 4 times the bank number for banks 0 to 2. For bank 3 they sit at 0x100, 0x10C, 0x118 and 0x124.
- R11: An access at byte offset 0x200 or above changes no state, does not raise `map_err`, and a read there returns zero.
- R12: An access below 0x200 that matches no register, including an offset that is not word-aligned, is treated as follows: a write changes no state, a read returns zero, and `map_err` is high for the one cycle that follows the access.
- R13: A read of any level register makes `lvl_read_pulse` high for the one cycle that follows the read.
- R14: Read data is registered. `bus_rdata` changes only in the cycle after `bus_re` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 12 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_re` |
| pin_in | input | 128 | Sampled pin inputs |
| pin_out | output | 128 | Driven level per pin (latch AND direction) |
| pin_chg | output | 128 | One-cycle strobe per pin whose driven level changed |
| lvl_read_pulse | output | 1 | One-cycle pulse after a level-register read |
| map_err | output | 1 | One-cycle pulse after an access to an unmapped offset below 0x200 |

## Verification
The assertions assume that `bus_we` and `bus_re` are never high in the same cycle. They also assume that `pin_in` is already synchronous to `clk`. The stimulus drives exactly one strobe per access, from a task that raises it for a single cycle, and it changes `pin_in` only between clock edges. The randomised phase picks each address from the mapped set, from holes below 0x200, from unaligned offsets and from the region above the window. This way the set, clear and direction paths see writes that change nothing, as well as writes that flip many pins at once.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int NBANK = 4;
  localparam int BANK_SEL_W = $clog2(NBANK);

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_LVL  = 3'd1,
    K_DIR  = 3'd2,
    K_SET  = 3'd3,
    K_CLR  = 3'd4,
    K_AFL  = 3'd5,
    K_AFU  = 3'd6
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e               kind;
    logic [BANK_SEL_W-1:0]   bank;
    logic                    in_win;
  } dec_t;

  // Byte offset of a bank's level register; the last bank sits in the upper page.
  function automatic int unsigned core_base(input int unsigned b);
    return (b == NBANK - 1) ? 32'h100 : 32'(4 * b);
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  localparam logic [ADDR_W-1:0] WIN_TOP = ADDR_W'(32'h200);
  localparam int unsigned OFS_DIR = 32'h00C;
  localparam int unsigned OFS_SET = 32'h018;
  localparam int unsigned OFS_CLR = 32'h024;
  localparam int unsigned AF_BASE = 32'h054;
  localparam int unsigned AF_STEP = 32'h008;

  always_comb begin
    dec.kind   = K_NONE;
    dec.bank   = '0;
    dec.in_win = (addr < WIN_TOP);
    for (int b = 0; b < NBANK; b++) begin
      if (addr == ADDR_W'(core_base(b))) begin
        dec.kind = K_LVL; dec.bank = BANK_SEL_W'(b);
      end
      if (addr == ADDR_W'(core_base(b) + OFS_DIR)) begin
        dec.kind = K_DIR; dec.bank = BANK_SEL_W'(b);
      end
      if (addr == ADDR_W'(core_base(b) + OFS_SET)) begin
        dec.kind = K_SET; dec.bank = BANK_SEL_W'(b);
      end
      if (addr == ADDR_W'(core_base(b) + OFS_CLR)) begin
        dec.kind = K_CLR; dec.bank = BANK_SEL_W'(b);
      end
      if (addr == ADDR_W'(AF_BASE + AF_STEP * b)) begin
        dec.kind = K_AFL; dec.bank = BANK_SEL_W'(b);
      end
      if (addr == ADDR_W'(AF_BASE + AF_STEP * b + 4)) begin
        dec.kind = K_AFU; dec.bank = BANK_SEL_W'(b);
      end
    end
    if (!dec.in_win) dec.kind = K_NONE;
  end

endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_dir,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic              wr_afl,
  input  logic              wr_afu,
  input  logic [BANK_W-1:0] wdata,
  output logic [BANK_W-1:0] dir_q,
  output logic [BANK_W-1:0] lat_q,
  output logic [BANK_W-1:0] afl_q,
  output logic [BANK_W-1:0] afu_q,
  output logic [BANK_W-1:0] drive_q,
  output logic [BANK_W-1:0] chg_q
);

  logic [BANK_W-1:0] dir_n, lat_n, drive_n;

  always_comb begin
    dir_n = wr_dir ? wdata : dir_q;
    lat_n = lat_q;
    if (wr_set) lat_n = lat_q | wdata;
    else if (wr_clr) lat_n = lat_q & ~wdata;
    drive_n = lat_n & dir_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      lat_q   <= '0;
      afl_q   <= '0;
      afu_q   <= '0;
      drive_q <= '0;
      chg_q   <= '0;
    end else begin
      dir_q   <= dir_n;
      lat_q   <= lat_n;
      drive_q <= drive_n;
      chg_q   <= drive_n ^ drive_q;
      if (wr_afl) afl_q <= wdata;
      if (wr_afu) afu_q <= wdata;
    end
  end

  p_set_or_r2: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((lat_q & $past(wdata)) == $past(wdata)));

  p_clr_bits_r3: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> ((lat_q & $past(wdata)) == '0));

  p_drive_needs_dir_r7: assert property (@(posedge clk) disable iff (rst)
    ((drive_q & ~dir_q) == '0));

  p_chg_real_r8: assert property (@(posedge clk) disable iff (rst)
    (|chg_q) |-> (drive_q != $past(drive_q)));

  p_chg_needs_write_r8: assert property (@(posedge clk) disable iff (rst)
    (|chg_q) |-> $past(wr_dir || wr_set || wr_clr));

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_port_pkg::*;
#(
  parameter int BANK_W = 32
) (
  input  dec_t                          dec,
  input  logic [NBANK*BANK_W-1:0]       pin_in,
  input  logic [NBANK-1:0][BANK_W-1:0]  dir_w,
  input  logic [NBANK-1:0][BANK_W-1:0]  lat_w,
  input  logic [NBANK-1:0][BANK_W-1:0]  afl_w,
  input  logic [NBANK-1:0][BANK_W-1:0]  afu_w,
  output logic [BANK_W-1:0]             rd_nxt
);

  logic [BANK_W-1:0] sel_dir, sel_lat, sel_in;

  assign sel_dir = dir_w[dec.bank];
  assign sel_lat = lat_w[dec.bank];
  assign sel_in  = pin_in[dec.bank*BANK_W +: BANK_W];

  always_comb begin
    unique case (dec.kind)
      K_LVL:   rd_nxt = (sel_lat & sel_dir) | (sel_in & ~sel_dir);
      K_DIR:   rd_nxt = sel_dir;
      K_AFL:   rd_nxt = afl_w[dec.bank];
      K_AFU:   rd_nxt = afu_w[dec.bank];
      default: rd_nxt = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic                    bus_we,
  input  logic                    bus_re,
  input  logic [BANK_W-1:0]       bus_wdata,
  output logic [BANK_W-1:0]       bus_rdata,
  input  logic [NBANK*BANK_W-1:0] pin_in,
  output logic [NBANK*BANK_W-1:0] pin_out,
  output logic [NBANK*BANK_W-1:0] pin_chg,
  output logic                    lvl_read_pulse,
  output logic                    map_err
);

  dec_t dec;
  logic [NBANK-1:0][BANK_W-1:0] dir_w, lat_w, afl_w, afu_w, drv_w, chg_w;
  logic [BANK_W-1:0] rd_nxt;
  logic hole;

  gpio_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic hit;
    assign hit = bus_we && (dec.bank == BANK_SEL_W'(g));

    gpio_pin_bank #(.BANK_W(BANK_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_dir  (hit && dec.kind == K_DIR),
      .wr_set  (hit && dec.kind == K_SET),
      .wr_clr  (hit && dec.kind == K_CLR),
      .wr_afl  (hit && dec.kind == K_AFL),
      .wr_afu  (hit && dec.kind == K_AFU),
      .wdata   (bus_wdata),
      .dir_q   (dir_w[g]),
      .lat_q   (lat_w[g]),
      .afl_q   (afl_w[g]),
      .afu_q   (afu_w[g]),
      .drive_q (drv_w[g]),
      .chg_q   (chg_w[g])
    );

    assign pin_out[g*BANK_W +: BANK_W] = drv_w[g];
    assign pin_chg[g*BANK_W +: BANK_W] = chg_w[g];
  end

  gpio_rd_mux #(.BANK_W(BANK_W)) u_mux (
    .dec    (dec),
    .pin_in (pin_in),
    .dir_w  (dir_w),
    .lat_w  (lat_w),
    .afl_w  (afl_w),
    .afu_w  (afu_w),
    .rd_nxt (rd_nxt)
  );

  assign hole = dec.in_win && (dec.kind == K_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata      <= '0;
      lvl_read_pulse <= 1'b0;
      map_err        <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= rd_nxt;
      lvl_read_pulse <= bus_re && (dec.kind == K_LVL);
      map_err        <= (bus_we || bus_re) && hole;
    end
  end

  p_wo_reads_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (dec.kind == K_SET || dec.kind == K_CLR)) |=> (bus_rdata == '0));

  p_above_window_r11: assert property (@(posedge clk) disable iff (rst)
    ((bus_we || bus_re) && !dec.in_win) |=> ($stable(pin_out) && !map_err));

  p_err_after_access_r12: assert property (@(posedge clk) disable iff (rst)
    map_err |-> $past(bus_we || bus_re));

  p_notify_after_read_r13: assert property (@(posedge clk) disable iff (rst)
    lvl_read_pulse |-> $past(bus_re));

  p_rdata_hold_r14: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));

endmodule

// File: tb/tb_gpio_port_regs.sv
module tb_gpio_port_regs;

  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [11:0]  bus_addr = '0;
  logic         bus_we = 1'b0;
  logic         bus_re = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [127:0] pin_in = '0;
  logic [127:0] pin_out;
  logic [127:0] pin_chg;
  logic         lvl_read_pulse;
  logic         map_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit started = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_port_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_chg(pin_chg), .lvl_read_pulse(lvl_read_pulse), .map_err(map_err)
  );

  // Reference model state
  logic [31:0]  m_dir [4];
  logic [31:0]  m_lat [4];
  logic [31:0]  m_afl [4];
  logic [31:0]  m_afu [4];
  logic [31:0]  m_rd;
  logic [127:0] m_out, m_chg;
  bit           m_err, m_rp;
  string        rd_tag = "R1";
  string        out_tag = "R1";
  string        err_tag = "R12";

  // kind: 0 hole, 1 level, 2 dir, 3 set, 4 clear, 5 af low, 6 af high, 7 above window
  task automatic ref_dec(input int a, output int k, output int b);
    k = (a >= 'h200) ? 7 : 0;
    b = 0;
    for (int i = 0; i < 4; i++) begin
      int base;
      base = (i == 3) ? 'h100 : 4 * i;
      if (a == base)          begin k = 1; b = i; end
      if (a == base + 'h0C)   begin k = 2; b = i; end
      if (a == base + 'h18)   begin k = 3; b = i; end
      if (a == base + 'h24)   begin k = 4; b = i; end
      if (a == 'h54 + 8 * i)  begin k = 5; b = i; end
      if (a == 'h58 + 8 * i)  begin k = 6; b = i; end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_dir[i] = '0; m_lat[i] = '0; m_afl[i] = '0; m_afu[i] = '0;
      end
      m_rd = '0; m_out = '0; m_chg = '0; m_err = 0; m_rp = 0;
      started = 1;
    end else begin
      int k, b;
      logic [127:0] nout;
      ref_dec(int'(bus_addr), k, b);
      m_err = 0; m_rp = 0;
      if (bus_we || bus_re) begin
        m_err = (k == 0);
        err_tag = (k == 7) ? "R11" : "R12";
      end
      if (bus_re) begin
        case (k)
          1: begin
               m_rd = (m_lat[b] & m_dir[b]) | (pin_in[b*32 +: 32] & ~m_dir[b]);
               m_rp = 1;
               rd_tag = (b == 3) ? "R10" : "R6";
             end
          2: begin m_rd = m_dir[b]; rd_tag = (b == 3) ? "R10" : "R5"; end
          3, 4: begin m_rd = '0; rd_tag = "R4"; end
          5: begin m_rd = m_afl[b]; rd_tag = "R9"; end
          6: begin m_rd = m_afu[b]; rd_tag = "R9"; end
          7: begin m_rd = '0; rd_tag = "R11"; end
          default: begin m_rd = '0; rd_tag = "R12"; end
        endcase
      end else begin
        rd_tag = "R14";
      end
      if (bus_we) begin
        case (k)
          2: begin m_dir[b] = bus_wdata; out_tag = "R5"; end
          3: begin m_lat[b] = m_lat[b] | bus_wdata; out_tag = "R2"; end
          4: begin m_lat[b] = m_lat[b] & ~bus_wdata; out_tag = "R3"; end
          5: m_afl[b] = bus_wdata;
          6: m_afu[b] = bus_wdata;
          7: out_tag = "R11";
          0: out_tag = "R12";
          default: ;
        endcase
      end
      for (int i = 0; i < 4; i++) nout[i*32 +: 32] = m_lat[i] & m_dir[i];
      m_chg = nout ^ m_out;
      m_out = nout;
    end
  end

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk(rst ? "R1" : rd_tag, 128'(bus_rdata), 128'(m_rd));
      chk(rst ? "R1" : out_tag, pin_out, m_out);
      chk(rst ? "R1" : "R8", pin_chg, m_chg);
      chk(rst ? "R1" : err_tag, 128'(map_err), 128'(m_err));
      chk(rst ? "R1" : "R13", 128'(lvl_read_pulse), 128'(m_rp));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    bus_addr = 12'(a); bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  int alist [32] = '{'h000, 'h004, 'h008, 'h100, 'h00C, 'h010, 'h014, 'h10C,
                     'h018, 'h01C, 'h020, 'h118, 'h024, 'h028, 'h02C, 'h124,
                     'h054, 'h058, 'h05C, 'h060, 'h064, 'h068, 'h06C, 'h070,
                     'h030, 'h1FC, 'h002, 'h074, 'h200, 'h3FC, 'hFFC, 'h130};

  initial begin
    #(CLK_NS * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset values visible through reads
    rd('h00C); rd('h054); rd('h000);
    // R5, R2, R7, R8: outputs appear only where direction is set
    wr('h00C, 32'h0000FFFF);
    wr('h018, 32'hFF00FF00);
    wr('h018, 32'hFF00FF00);   // R8: already set, no change strobe
    wr('h024, 32'h0F000F00);   // R3
    pin_in = {4{32'hA5A5C3C3}};
    rd('h000);                 // R6, R13
    rd('h018); rd('h024);      // R4
    wr('h00C, 32'hFFFF0000);   // R8: direction flip drops and raises pins
    rd('h00C);
    // R10: bank 3 in the upper page
    wr('h10C, 32'h80000001);
    wr('h118, 32'hFFFFFFFF);
    rd('h100); rd('h10C); rd('h118); rd('h124);
    wr('h124, 32'h00000001);
    // R9: alternate-function storage
    for (int i = 0; i < 4; i++) begin
      wr('h54 + 8 * i, 32'h11110000 + i);
      wr('h58 + 8 * i, 32'h22220000 + i);
    end
    for (int i = 0; i < 8; i++) rd('h54 + 4 * i);
    // R12: holes, unaligned
    wr('h030, 32'hFFFFFFFF); rd('h030);
    wr('h002, 32'hFFFFFFFF); rd('h002); rd('h1FC);
    // R11: above window
    wr('h200, 32'hFFFFFFFF); wr('h318, 32'hFFFFFFFF); rd('h200); rd('hFFC);
    rd('h00C);
    // Randomised mix
    for (int n = 0; n < 600; n++) begin
      int a;
      a = alist[$urandom_range(31, 0)];
      if (n % 7 == 0) pin_in = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(1, 0) == 1) wr(a, $urandom);
      else rd(a);
    end
    // mid-run reset
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd('h10C); rd('h070);
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule